// File: doc/BRIEF.md
# Key-Locked System Control Register Bank

This block is a bank of 32-bit control words that a processor reaches through a simple synchronous bus with a byte offset inside a 4 KiB window. Each word has an access class: read-write, read-only, write-only or unmapped. Every access is checked against that class, and a violation raises an error flag in the same cycle as the access.

Ordinary writes are guarded by a lock. The lock is set by writing a 16-bit key to one word and cleared by writing a different key to another. The bank comes out of reset locked. While it is locked, only the key words and a one-bit latch word accept writes.

One read-write word doubles as a reset trigger. An accepted write with its bit 0 set raises a one-cycle soft-reset request. The clock-setup words load fixed values at reset. Two read-only words return an identity value and a boot value, both fixed by parameters.

Top module: `keyed_ctrl_bank`

## Requirements
- R1: After reset, `locked` is 1 and `soft_rst_req` is 0. The three PLL words (0x010, 0x014, 0x018) read 0x0001A008, the UART clock word (0x01C) reads 0x00003F03, and every other stored word reads 0.
- R2: An accepted write to 0x004 whose `bus_wdata[15:0]` equals 0x767B sets `locked` to 1 from the next cycle. Any other data leaves `locked` unchanged.
- R3: An accepted write to 0x008 whose `bus_wdata[15:0]` equals 0xDF0D clears `locked` to 0 from the next cycle. Any other data leaves `locked` unchanged.
- R4: While `locked` is 1, writes to read-write words other than 0x000 are discarded and raise no error.
- R5: Word 0x000 keeps only `bus_wdata[0]` and accepts writes whether or not the bank is locked. A read returns that bit zero-extended.
- R6: The access classes are as follows. Write-only: 0x004, 0x008 and 0x024. Read-only: 0x00C (lock state in bit 0), 0x028 (parameter `ID_VALUE`) and 0x02C (parameter `BOOT_VALUE`). Read-write: 0x000, 0x010 to 0x020, and 0x040 + 4k for k < `NUM_GP`. Every other offset is unmapped.
- R7: A write to a read-only or unmapped offset raises `bus_err` in the same cycle and changes no state.
- R8: A read of a write-only or unmapped offset raises `bus_err` in the same cycle. The read still returns the word stored there: the last value written for 0x024, and 0 for the key words and unmapped offsets.
- R9: An accepted, unlocked write to 0x020 with bit 0 set drives `soft_rst_req` high for exactly the one cycle after the write edge. The written word stays stored. A write with bit 0 clear raises no request.
- R10: A legal read returns the stored word combinationally in the same cycle, with `bus_err` low.
- R11: An offset with `bus_addr[1:0]` not equal to 0 is treated as unmapped.
- R12: While `bus_sel` is low, `bus_err` stays low and no state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (12) | Byte offset in the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| bus_err | output | 1 | Access-class violation, same cycle |
| locked | output | 1 | Lock state |
| soft_rst_req | output | 1 | One-cycle soft-reset request |

## Verification
A wrong lock state shows up on `locked` one cycle after the key write that caused it. It also shows on the next guarded write, whose read-back then returns either the old word or the new word, contrary to expectation. A decode fault shows as a wrong `bus_err` or wrong `bus_rdata` in the very cycle of the access. A broken trigger path shows as a missing, doubled or spurious `soft_rst_req` in the cycle after the write. Because every access compares `bus_err` and every read compares `bus_rdata`, a corrupted word is caught on its next read.

// File: rtl/kcb_pkg.sv
package kcb_pkg;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_RO   = 2'd1,
    ACC_WO   = 2'd2,
    ACC_RW   = 2'd3
  } acc_e;

  typedef enum logic [3:0] {
    RID_NONE,
    RID_LATCH,
    RID_LOCK,
    RID_UNLOCK,
    RID_LSTAT,
    RID_PLL,
    RID_UCLK,
    RID_RSTC,
    RID_CAL,
    RID_ID,
    RID_BOOT,
    RID_GP
  } rid_e;

  typedef struct packed {
    rid_e       rid;
    logic [7:0] idx;
    acc_e       acc;
  } dec_t;

  localparam logic [15:0] LOCK_KEY   = 16'h767B;
  localparam logic [15:0] UNLOCK_KEY = 16'hDF0D;
  localparam logic [31:0] PLL_RST    = 32'h0001_A008;
  localparam logic [31:0] UCLK_RST   = 32'h0000_3F03;

endpackage

// File: rtl/kcb_decode.sv
module kcb_decode
  import kcb_pkg::*;
#(
  parameter int unsigned AW      = 12,
  parameter int unsigned NUM_PLL = 3,
  parameter int unsigned GP_BASE = 16,
  parameter int unsigned NUM_GP  = 8
) (
  input  logic [AW-1:0] addr,
  output dec_t          dec
);

  localparam int unsigned WIW = AW - 2;
  localparam logic [WIW-1:0] W_LATCH  = WIW'(0);
  localparam logic [WIW-1:0] W_LOCK   = WIW'(1);
  localparam logic [WIW-1:0] W_UNLOCK = WIW'(2);
  localparam logic [WIW-1:0] W_LSTAT  = WIW'(3);
  localparam logic [WIW-1:0] W_PLL0   = WIW'(4);
  localparam logic [WIW-1:0] W_UCLK   = WIW'(4 + NUM_PLL);
  localparam logic [WIW-1:0] W_RSTC   = WIW'(5 + NUM_PLL);
  localparam logic [WIW-1:0] W_CAL    = WIW'(6 + NUM_PLL);
  localparam logic [WIW-1:0] W_ID     = WIW'(7 + NUM_PLL);
  localparam logic [WIW-1:0] W_BOOT   = WIW'(8 + NUM_PLL);
  localparam logic [WIW-1:0] W_GP0    = WIW'(GP_BASE);
  localparam logic [WIW-1:0] W_GPE    = WIW'(GP_BASE + NUM_GP);

  logic [WIW-1:0] word;
  assign word = addr[AW-1:2];

  always_comb begin
    dec = '{rid: RID_NONE, idx: 8'd0, acc: ACC_NONE};
    if (addr[1:0] == 2'b00) begin
      if (word == W_LATCH)       dec = '{rid: RID_LATCH,  idx: 8'd0, acc: ACC_RW};
      else if (word == W_LOCK)   dec = '{rid: RID_LOCK,   idx: 8'd0, acc: ACC_WO};
      else if (word == W_UNLOCK) dec = '{rid: RID_UNLOCK, idx: 8'd0, acc: ACC_WO};
      else if (word == W_LSTAT)  dec = '{rid: RID_LSTAT,  idx: 8'd0, acc: ACC_RO};
      else if (word >= W_PLL0 && word < W_UCLK)
        dec = '{rid: RID_PLL, idx: 8'(word - W_PLL0), acc: ACC_RW};
      else if (word == W_UCLK)   dec = '{rid: RID_UCLK,   idx: 8'd0, acc: ACC_RW};
      else if (word == W_RSTC)   dec = '{rid: RID_RSTC,   idx: 8'd0, acc: ACC_RW};
      else if (word == W_CAL)    dec = '{rid: RID_CAL,    idx: 8'd0, acc: ACC_WO};
      else if (word == W_ID)     dec = '{rid: RID_ID,     idx: 8'd0, acc: ACC_RO};
      else if (word == W_BOOT)   dec = '{rid: RID_BOOT,   idx: 8'd0, acc: ACC_RO};
      else if (word >= W_GP0 && word < W_GPE)
        dec = '{rid: RID_GP, idx: 8'(word - W_GP0), acc: ACC_RW};
    end
  end

endmodule

// File: rtl/kcb_lock.sv
module kcb_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_req,
  output logic locked
);

  logic lock_q, lock_d;

  always_comb begin
    lock_d = lock_q;
    if (set_req)      lock_d = 1'b1;
    else if (clr_req) lock_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_q <= 1'b1;
    else        lock_q <= lock_d;
  end

  assign locked = lock_q;

  AST_LOCK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    set_req |=> locked); // R2
  AST_UNLOCK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !set_req) |=> !locked); // R3
  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_req && !clr_req) |=> $stable(locked)); // R2

endmodule

// File: rtl/kcb_regs.sv
module kcb_regs
  import kcb_pkg::*;
#(
  parameter int unsigned NUM_PLL    = 3,
  parameter int unsigned NUM_GP     = 8,
  parameter logic [31:0] ID_VALUE   = 32'h0A5C_0001,
  parameter logic [31:0] BOOT_VALUE = 32'h0000_0001
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  dec_t        dec,
  input  logic [31:0] wdata,
  input  logic        locked,
  output logic [31:0] rd_word,
  output logic        soft_pulse
);

  logic        latch_q, latch_d;
  logic [31:0] uclk_q, uclk_d;
  logic [31:0] rstc_q, rstc_d;
  logic [31:0] cal_q, cal_d;
  logic        soft_q, soft_d;

  always_comb begin
    latch_d = latch_q;
    uclk_d  = uclk_q;
    rstc_d  = rstc_q;
    cal_d   = cal_q;
    if (wr_en) begin
      case (dec.rid)
        RID_LATCH: latch_d = wdata[0];
        RID_UCLK:  uclk_d  = wdata;
        RID_RSTC:  rstc_d  = wdata;
        RID_CAL:   cal_d   = wdata;
        default: ;
      endcase
    end
    soft_d = wr_en && (dec.rid == RID_RSTC) && wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= 1'b0;
      uclk_q  <= UCLK_RST;
      rstc_q  <= 32'd0;
      cal_q   <= 32'd0;
      soft_q  <= 1'b0;
    end else begin
      latch_q <= latch_d;
      uclk_q  <= uclk_d;
      rstc_q  <= rstc_d;
      cal_q   <= cal_d;
      soft_q  <= soft_d;
    end
  end

  logic [31:0] pll_rd [NUM_PLL];
  logic [31:0] gp_rd  [NUM_GP];

  for (genvar g = 0; g < NUM_PLL; g++) begin : g_pll
    logic [31:0] q;
    logic        ld;
    assign ld = wr_en && (dec.rid == RID_PLL) && (dec.idx == 8'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= PLL_RST;
      else if (ld) q <= wdata;
    end
    assign pll_rd[g] = q;
  end

  for (genvar g = 0; g < NUM_GP; g++) begin : g_gp
    logic [31:0] q;
    logic        ld;
    assign ld = wr_en && (dec.rid == RID_GP) && (dec.idx == 8'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= 32'd0;
      else if (ld) q <= wdata;
    end
    assign gp_rd[g] = q;
  end

  always_comb begin
    rd_word = 32'd0;
    case (dec.rid)
      RID_LATCH: rd_word = {31'd0, latch_q};
      RID_LSTAT: rd_word = {31'd0, locked};
      RID_UCLK:  rd_word = uclk_q;
      RID_RSTC:  rd_word = rstc_q;
      RID_CAL:   rd_word = cal_q;
      RID_ID:    rd_word = ID_VALUE;
      RID_BOOT:  rd_word = BOOT_VALUE;
      RID_PLL:
        for (int i = 0; i < NUM_PLL; i++)
          if (dec.idx == 8'(i)) rd_word = pll_rd[i];
      RID_GP:
        for (int i = 0; i < NUM_GP; i++)
          if (dec.idx == 8'(i)) rd_word = gp_rd[i];
      default: ;
    endcase
  end

  assign soft_pulse = soft_q;

  AST_LOCKED_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && locked) |-> (dec.rid == RID_LATCH)); // R4
  AST_SOFT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    soft_pulse |-> $past(wr_en && (dec.rid == RID_RSTC) && wdata[0])); // R9
  AST_UCLK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && dec.rid == RID_UCLK) |=> $stable(uclk_q)); // R7

endmodule

// File: rtl/keyed_ctrl_bank.sv
module keyed_ctrl_bank
  import kcb_pkg::*;
#(
  parameter int unsigned AW         = 12,
  parameter int unsigned NUM_PLL    = 3,
  parameter int unsigned GP_BASE    = 16,
  parameter int unsigned NUM_GP     = 8,
  parameter logic [31:0] ID_VALUE   = 32'h0A5C_0001,
  parameter logic [31:0] BOOT_VALUE = 32'h0000_0001
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          bus_err,
  output logic          locked,
  output logic          soft_rst_req
);

  dec_t        dec;
  logic        rd_ok, wr_ok, wr_legal, exempt, commit;
  logic        set_req, clr_req;
  logic [31:0] rd_word;

  kcb_decode #(
    .AW(AW), .NUM_PLL(NUM_PLL), .GP_BASE(GP_BASE), .NUM_GP(NUM_GP)
  ) u_decode (
    .addr (bus_addr),
    .dec  (dec)
  );

  assign rd_ok    = (dec.acc == ACC_RO) || (dec.acc == ACC_RW);
  assign wr_ok    = (dec.acc == ACC_WO) || (dec.acc == ACC_RW);
  assign bus_err  = bus_sel && (bus_we ? !wr_ok : !rd_ok);
  assign wr_legal = bus_sel && bus_we && wr_ok;
  assign exempt   = (dec.rid == RID_LATCH);
  assign commit   = wr_legal && (dec.rid != RID_LOCK) && (dec.rid != RID_UNLOCK)
                    && (exempt || !locked);
  assign set_req  = wr_legal && (dec.rid == RID_LOCK)   && (bus_wdata[15:0] == LOCK_KEY);
  assign clr_req  = wr_legal && (dec.rid == RID_UNLOCK) && (bus_wdata[15:0] == UNLOCK_KEY);

  kcb_lock u_lock (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_req (set_req),
    .clr_req (clr_req),
    .locked  (locked)
  );

  kcb_regs #(
    .NUM_PLL(NUM_PLL), .NUM_GP(NUM_GP), .ID_VALUE(ID_VALUE), .BOOT_VALUE(BOOT_VALUE)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (commit),
    .dec        (dec),
    .wdata      (bus_wdata),
    .locked     (locked),
    .rd_word    (rd_word),
    .soft_pulse (soft_rst_req)
  );

  assign bus_rdata = (bus_sel && !bus_we) ? rd_word : 32'd0;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |-> !bus_err); // R12
  AST_ERR_KEEPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_err) |=> $stable(locked)); // R7
  AST_IDLE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |=> !soft_rst_req); // R12

endmodule

// File: tb/keyed_ctrl_bank_tb.sv
module keyed_ctrl_bank_tb;

  localparam logic [31:0] IDV  = 32'h0A5C_0001;
  localparam logic [31:0] BOOT = 32'h0000_0001;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = 12'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        bus_err, locked, soft_rst_req;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  keyed_ctrl_bank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .locked(locked), .soft_rst_req(soft_rst_req)
  );

  // reference model
  bit          m_lock, m_latch;
  logic [31:0] m_pll [3];
  logic [31:0] m_gp [8];
  logic [31:0] m_uclk, m_rstc, m_cal;

  function automatic void model_reset();
    m_lock = 1; m_latch = 0;
    for (int i = 0; i < 3; i++) m_pll[i] = 32'h0001_A008;
    for (int i = 0; i < 8; i++) m_gp[i] = 32'd0;
    m_uclk = 32'h0000_3F03; m_rstc = 0; m_cal = 0;
  endfunction

  // 0 none, 1 ro, 2 wo, 3 rw
  function automatic int cls(logic [11:0] a);
    int w = int'(a[11:2]);
    if (a[1:0] != 2'b00) return 0;
    if (w == 0 || (w >= 4 && w <= 8) || (w >= 16 && w <= 23)) return 3;
    if (w == 1 || w == 2 || w == 9) return 2;
    if (w == 3 || w == 10 || w == 11) return 1;
    return 0;
  endfunction

  function automatic logic [31:0] mread(logic [11:0] a);
    int w = int'(a[11:2]);
    if (a[1:0] != 2'b00) return 32'd0;
    case (w)
      0: return {31'd0, m_latch};
      3: return {31'd0, m_lock};
      4, 5, 6: return m_pll[w-4];
      7: return m_uclk;
      8: return m_rstc;
      9: return m_cal;
      10: return IDV;
      11: return BOOT;
      default: if (w >= 16 && w <= 23) return m_gp[w-16];
    endcase
    return 32'd0;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic op(string tag, bit we, logic [11:0] a, logic [31:0] d);
    int c, w;
    bit exp_err, exp_soft;
    @(negedge clk);
    bus_sel = 1; bus_we = we; bus_addr = a; bus_wdata = d;
    #1;
    c = cls(a);
    w = int'(a[11:2]);
    exp_err = we ? !(c == 2 || c == 3) : !(c == 1 || c == 3);
    chk(tag, "bus_err", {31'd0, bus_err}, {31'd0, exp_err});
    if (!we) chk(tag, "bus_rdata", bus_rdata, mread(a));
    exp_soft = 0;
    if (we && !exp_err) begin
      if (w == 1) begin
        if (d[15:0] == 16'h767B) m_lock = 1;
      end else if (w == 2) begin
        if (d[15:0] == 16'hDF0D) m_lock = 0;
      end else if (w == 0) begin
        m_latch = d[0];
      end else if (!m_lock) begin
        if (w >= 4 && w <= 6) m_pll[w-4] = d;
        else if (w == 7) m_uclk = d;
        else if (w == 8) begin m_rstc = d; exp_soft = d[0]; end
        else if (w == 9) m_cal = d;
        else if (w >= 16 && w <= 23) m_gp[w-16] = d;
      end
    end
    @(posedge clk);
    #1;
    bus_sel = 0; bus_we = 0;
    chk(tag, "locked", {31'd0, locked}, {31'd0, m_lock});
    chk(tag, "soft_rst_req", {31'd0, soft_rst_req}, {31'd0, exp_soft});
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #2;
    // R1 reset state
    chk("R1", "locked", {31'd0, locked}, 32'd1);
    chk("R1", "soft_rst_req", {31'd0, soft_rst_req}, 32'd0);
    op("R1", 0, 12'h010, 0);
    op("R1", 0, 12'h014, 0);
    op("R1", 0, 12'h018, 0);
    op("R1", 0, 12'h01C, 0);
    op("R1", 0, 12'h00C, 0);
    // R4 locked writes dropped
    op("R4", 1, 12'h010, 32'h1234_5678);
    op("R4", 0, 12'h010, 0);
    op("R4", 1, 12'h020, 32'h1);
    op("R4", 0, 12'h020, 0);
    // R3 wrong unlock key
    op("R3", 1, 12'h008, 32'hFFFF_DF0C);
    // R5 latch while locked
    op("R5", 1, 12'h000, 32'hFFFF_FFFF);
    op("R5", 0, 12'h000, 0);
    // R3 correct unlock (upper bits ignored)
    op("R3", 1, 12'h008, 32'hABCD_DF0D);
    op("R3", 0, 12'h00C, 0);
    op("R10", 1, 12'h014, 32'hCAFE_F00D);
    op("R10", 0, 12'h014, 0);
    op("R10", 1, 12'h05C, 32'h0BAD_BEEF);
    op("R10", 0, 12'h05C, 0);
    // R7 / R6 read-only and unmapped writes
    op("R7", 1, 12'h028, 32'hFFFF_FFFF);
    op("R6", 0, 12'h028, 0);
    op("R6", 0, 12'h02C, 0);
    op("R7", 1, 12'h00C, 32'h0);
    op("R7", 1, 12'h300, 32'h55);
    // R8 write-only reads
    op("R8", 1, 12'h024, 32'h0000_005A);
    op("R8", 0, 12'h024, 0);
    op("R8", 0, 12'h004, 0);
    op("R6", 0, 12'h100, 0);
    // R11 unaligned
    op("R11", 1, 12'h011, 32'h7777_7777);
    op("R11", 0, 12'h010, 0);
    op("R11", 0, 12'h012, 0);
    // R9 soft reset pulse
    op("R9", 1, 12'h020, 32'h0000_0003);
    op("R9", 0, 12'h020, 0);
    op("R9", 1, 12'h020, 32'h0000_0002);
    op("R9", 1, 12'h020, 32'h0000_0001);
    op("R9", 1, 12'h020, 32'h0000_0001);
    op("R9", 0, 12'h00C, 0);
    // R12 idle cycle with write lines active
    @(negedge clk);
    bus_sel = 0; bus_we = 1; bus_addr = 12'h010; bus_wdata = 32'hDEAD_DEAD;
    #1 chk("R12", "bus_err", {31'd0, bus_err}, 32'd0);
    @(posedge clk); #1;
    chk("R12", "soft_rst_req", {31'd0, soft_rst_req}, 32'd0);
    bus_we = 0;
    op("R12", 0, 12'h010, 0);
    // R2 lock keys
    op("R2", 1, 12'h004, 32'h0000_767A);
    op("R2", 1, 12'h004, 32'h1111_767B);
    op("R2", 1, 12'h018, 32'h1);
    op("R2", 0, 12'h018, 0);
    // random phase
    for (int k = 0; k < 600; k++) begin
      int unsigned r = $urandom;
      int unsigned w = $urandom_range(0, 26);
      logic [11:0] a = {w[9:0], 2'b00};
      logic [31:0] d = $urandom;
      if (r[3:0] == 4'd0) a[1:0] = 2'($urandom_range(1, 3));
      if (w == 1 && r[4]) d[15:0] = 16'h767B;
      if (w == 2 && r[5]) d[15:0] = 16'hDF0D;
      op("R10", r[8], a, d);
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule